// File: doc/BRIEF.md
# Multiplexed Processor Bus Bridge

This block sits between a RISC processor whose 32-bit address and data share one set of pins and an internal peripheral bus that keeps address, write data and read data on separate wires. It holds the upper address from the shared pins while the address-latch strobe is high. It then runs a small handshake engine. For each data beat the engine issues a one-clock internal read or write strobe and answers the processor with a one-clock acknowledge. A transfer is either a single word or a multi-word cache-refill burst whose word-in-block index arrives on two dedicated, live address pins.

The same block clocks the processor and brings it out of reset in a fixed order. Cold reset lifts first and warm reset follows. It also routes two peripheral interrupt requests, one from the infrared link and one from the audio converter, onto chosen lines of the processor's four active-low interrupt inputs. The shared pins are modelled as separate input, output and output-enable signals. The pad ring combines them into the tri-state pin.

Top module: `mbb_bridge`

## Requirements
- R1: On every clock edge where `cpu_ale_i` is high, `per_addr_o[31:4]` loads `cpu_ad_i[31:4]`. It holds that value at every other edge.
- R2: `per_addr_o[3:2]` equals `cpu_word_i[1:0]` with no clock delay, so the word index steps live through a burst.
- R3: In a read beat, `per_rd_o` is high for exactly one clock. In the next clock `cpu_ack_n_o` is low and `cpu_ad_o` carries the `per_din_i` value present at the end of the strobe clock.
- R4: In a write beat, `per_wr_o` is high for exactly one clock and `per_dout_o` shows the `cpu_ad_i` value present at the clock edge that started the beat. An acknowledge (`cpu_ack_n_o` low for one clock) follows in the next clock.
- R5: A transfer starts once `cpu_ale_i` is low, `cpu_cip_n_i` is low and `cpu_rd_n_i` or `cpu_wr_n_i` is low. Beats repeat, each with its own strobe and acknowledge. The transfer ends after the beat during whose strobe clock `cpu_last_n_i` was low.
- R6: `cpu_ad_oe_o` is high only in the strobe and acknowledge clocks of read beats. It is never high in writes, and it drops in the clock right after the final acknowledge.
- R7: `per_be_o` is the bitwise inverse of `cpu_be_n_i` (active-high byte lanes), with no clock delay.
- R8: After reset release, `cpu_cold_n_o` stays low for COLD_CYC clocks (default 64). `cpu_warm_n_o` stays low for a further WARM_CYC clocks (default 32). Once high, neither returns low.
- R9: A low `ir_irq_n_i` pulls `cpu_int_n_o[IR_LINE]` (default line 0) low one clock later. A low `dac_irq_n_i` does the same to `cpu_int_n_o[DAC_LINE]` (default line 1). Lines with no source stay high.
- R10: `cpu_mclk_o` is the bridge clock itself.
- R11: While `rst_n` is low, `cpu_ack_n_o` is high, `cpu_ad_oe_o`, `per_rd_o` and `per_wr_o` are low, `cpu_int_n_o` is all ones and both processor resets are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cpu_mclk_o | output | 1 | Master clock to the processor |
| cpu_ad_i | input | 32 | Shared address/data pins, input side |
| cpu_ad_o | output | 32 | Shared address/data pins, read data driven out |
| cpu_ad_oe_o | output | 1 | Drive enable for cpu_ad_o |
| cpu_word_i | input | 2 | Word-in-block address bits 3:2 |
| cpu_be_n_i | input | 4 | Active-low byte enables |
| cpu_ale_i | input | 1 | Address-latch strobe, active high |
| cpu_rd_n_i | input | 1 | Read request, active low |
| cpu_wr_n_i | input | 1 | Write request, active low |
| cpu_cip_n_i | input | 1 | Transfer in progress, active low |
| cpu_last_n_i | input | 1 | Final beat marker, active low |
| cpu_ack_n_o | output | 1 | Beat acknowledge, active low |
| cpu_cold_n_o | output | 1 | Processor cold reset, active low |
| cpu_warm_n_o | output | 1 | Processor warm reset, active low |
| cpu_int_n_o | output | 4 | Processor interrupt inputs, active low |
| per_addr_o | output | 30 | Internal word address, bits 31:2 |
| per_be_o | output | 4 | Internal byte enables, active high |
| per_rd_o | output | 1 | Internal read strobe |
| per_wr_o | output | 1 | Internal write strobe |
| per_dout_o | output | 32 | Internal write data |
| per_din_i | input | 32 | Internal read data |
| ir_irq_n_i | input | 1 | Infrared link interrupt request, active low |
| dac_irq_n_i | input | 1 | Audio converter interrupt request, active low |

## Verification
Some properties are checked on every cycle. The latched upper address moves only under the latch strobe, and each strobe lasts a single clock. Every acknowledge comes right after a strobe, and the read drive is released the clock after a final acknowledge. Cold reset always lifts no later than warm reset, and each interrupt request reaches its line one clock later. Other behaviour needs the bench's scenarios to show it. These are the actual values carried per beat, the word index stepping and wrapping through a burst, the exact length of each reset phase, and the merging of both requests.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  // Handshake engine states: idle, address held, strobe clock, acknowledge clock.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_BEAT = 2'd2,
    ST_ACK  = 2'd3
  } bus_st_e;

  localparam int unsigned WORD_BITS = 2;
  localparam int unsigned BYTE_OFS  = 2;
endpackage

// File: rtl/mbb_addr_latch.sv
module mbb_addr_latch import mbb_pkg::*; #(
  parameter int unsigned AD_W = 32,
  localparam int unsigned HI_LSB = BYTE_OFS + WORD_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ale_i,
  input  logic [AD_W-1:HI_LSB]   ad_hi_i,
  input  logic [WORD_BITS-1:0]   word_i,
  output logic [AD_W-1:BYTE_OFS] addr_o
);
  logic [AD_W-1:HI_LSB] hi_q;
  logic [AD_W-1:HI_LSB] hi_d;
  logic                 hi_en;

  assign hi_en = ale_i;

  always_comb begin
    hi_d = hi_q;
    if (hi_en) hi_d = ad_hi_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  // Word-in-block bits pass straight through so a burst can step them.
  assign addr_o = {hi_q, word_i};

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_i |=> addr_o[AD_W-1:HI_LSB] == $past(ad_hi_i)); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_i |=> $stable(addr_o[AD_W-1:HI_LSB])); // R1
endmodule

// File: rtl/mbb_bus_fsm.sv
module mbb_bus_fsm import mbb_pkg::*; #(
  parameter int unsigned AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale_i,
  input  logic            rd_n_i,
  input  logic            wr_n_i,
  input  logic            cip_n_i,
  input  logic            last_n_i,
  input  logic [AD_W-1:0] ad_i,
  input  logic [AD_W-1:0] per_din_i,
  output logic            ack_n_o,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe_o,
  output logic            per_rd_o,
  output logic            per_wr_o,
  output logic [AD_W-1:0] per_dout_o
);
  bus_st_e         st_q, st_d;
  logic            is_rd_q, is_rd_d, is_rd_en;
  logic            fin_q, fin_d, fin_en;
  logic [AD_W-1:0] rdat_q, rdat_d;
  logic            rdat_en;
  logic [AD_W-1:0] wdat_q, wdat_d;
  logic            wdat_en;
  logic            start;
  logic            to_beat;

  assign start   = !ale_i && !cip_n_i && (!rd_n_i || !wr_n_i);
  assign to_beat = ((st_q == ST_ADDR) && start) || ((st_q == ST_ACK) && !fin_q);

  // Next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ale_i) st_d = ST_ADDR;
      ST_ADDR: if (start) st_d = ST_BEAT;
      ST_BEAT: st_d = ST_ACK;
      ST_ACK:  st_d = fin_q ? ST_IDLE : ST_BEAT;
      default: st_d = ST_IDLE;
    endcase
  end

  // Clock enables and data paths
  assign is_rd_en = (st_q == ST_ADDR) && start;
  assign is_rd_d  = !rd_n_i;
  assign fin_en   = (st_q == ST_BEAT);
  assign fin_d    = !last_n_i;
  assign rdat_en  = (st_q == ST_BEAT) && is_rd_q;
  assign rdat_d   = per_din_i;
  assign wdat_en  = to_beat && ((st_q == ST_ADDR) ? rd_n_i : !is_rd_q);
  assign wdat_d   = ad_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      is_rd_q <= 1'b0;
      fin_q   <= 1'b0;
      rdat_q  <= '0;
      wdat_q  <= '0;
    end else begin
      st_q <= st_d;
      if (is_rd_en) is_rd_q <= is_rd_d;
      if (fin_en)   fin_q   <= fin_d;
      if (rdat_en)  rdat_q  <= rdat_d;
      if (wdat_en)  wdat_q  <= wdat_d;
    end
  end

  assign per_rd_o   = (st_q == ST_BEAT) && is_rd_q;
  assign per_wr_o   = (st_q == ST_BEAT) && !is_rd_q;
  assign ack_n_o    = (st_q != ST_ACK);
  assign ad_oe_o    = is_rd_q && ((st_q == ST_BEAT) || (st_q == ST_ACK));
  assign ad_o       = rdat_q;
  assign per_dout_o = wdat_q;

  AST_ONE_CLOCK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rd_o || per_wr_o) |=> !(per_rd_o || per_wr_o)); // R3
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |-> $past(per_rd_o || per_wr_o)); // R5
  AST_STROBE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rd_o || per_wr_o) |=> !ack_n_o); // R4
  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n_o && fin_q) |=> (!ad_oe_o && ack_n_o)); // R6
endmodule

// File: rtl/mbb_reset_seq.sv
module mbb_reset_seq #(
  parameter int unsigned COLD_CYC = 64,
  parameter int unsigned WARM_CYC = 32,
  localparam int unsigned TOTAL   = COLD_CYC + WARM_CYC,
  localparam int unsigned CW      = $clog2(TOTAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic cold_n_o,
  output logic warm_n_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != CW'(TOTAL));
  assign cnt_d  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cold_n_o = (cnt_q >= CW'(COLD_CYC));
  assign warm_n_o = (cnt_q >= CW'(TOTAL));

  AST_COLD_BEFORE_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    warm_n_o |-> cold_n_o); // R8
  AST_COLD_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cold_n_o |=> cold_n_o); // R8
  AST_WARM_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    warm_n_o |=> warm_n_o); // R8
endmodule

// File: rtl/mbb_irq_map.sv
module mbb_irq_map #(
  parameter int unsigned INT_W    = 4,
  parameter int unsigned IR_LINE  = 0,
  parameter int unsigned DAC_LINE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_req_n_i,
  input  logic             dac_req_n_i,
  output logic [INT_W-1:0] int_n_o
);
  logic [INT_W-1:0] line_req;
  logic [INT_W-1:0] int_q, int_d;

  for (genvar i = 0; i < INT_W; i++) begin : g_line
    assign line_req[i] = ((i == IR_LINE)  && !ir_req_n_i) ||
                         ((i == DAC_LINE) && !dac_req_n_i);
  end

  assign int_d = ~line_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= '1;
    else        int_q <= int_d;
  end

  assign int_n_o = int_q;

  AST_IR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_req_n_i |=> !int_n_o[IR_LINE]); // R9
  AST_DAC_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_req_n_i |=> !int_n_o[DAC_LINE]); // R9
endmodule

// File: rtl/mbb_bridge.sv
module mbb_bridge import mbb_pkg::*; #(
  parameter int unsigned AD_W     = 32,
  parameter int unsigned BE_W     = AD_W / 8,
  parameter int unsigned INT_W    = 4,
  parameter int unsigned IR_LINE  = 0,
  parameter int unsigned DAC_LINE = 1,
  parameter int unsigned COLD_CYC = 64,
  parameter int unsigned WARM_CYC = 32,
  localparam int unsigned HI_LSB  = BYTE_OFS + WORD_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   cpu_mclk_o,
  input  logic [AD_W-1:0]        cpu_ad_i,
  output logic [AD_W-1:0]        cpu_ad_o,
  output logic                   cpu_ad_oe_o,
  input  logic [WORD_BITS-1:0]   cpu_word_i,
  input  logic [BE_W-1:0]        cpu_be_n_i,
  input  logic                   cpu_ale_i,
  input  logic                   cpu_rd_n_i,
  input  logic                   cpu_wr_n_i,
  input  logic                   cpu_cip_n_i,
  input  logic                   cpu_last_n_i,
  output logic                   cpu_ack_n_o,
  output logic                   cpu_cold_n_o,
  output logic                   cpu_warm_n_o,
  output logic [INT_W-1:0]       cpu_int_n_o,
  output logic [AD_W-1:BYTE_OFS] per_addr_o,
  output logic [BE_W-1:0]        per_be_o,
  output logic                   per_rd_o,
  output logic                   per_wr_o,
  output logic [AD_W-1:0]        per_dout_o,
  input  logic [AD_W-1:0]        per_din_i,
  input  logic                   ir_irq_n_i,
  input  logic                   dac_irq_n_i
);
  assign cpu_mclk_o = clk;
  assign per_be_o   = ~cpu_be_n_i;

  mbb_addr_latch #(.AD_W(AD_W)) i_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_i   (cpu_ale_i),
    .ad_hi_i (cpu_ad_i[AD_W-1:HI_LSB]),
    .word_i  (cpu_word_i),
    .addr_o  (per_addr_o)
  );

  mbb_bus_fsm #(.AD_W(AD_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale_i      (cpu_ale_i),
    .rd_n_i     (cpu_rd_n_i),
    .wr_n_i     (cpu_wr_n_i),
    .cip_n_i    (cpu_cip_n_i),
    .last_n_i   (cpu_last_n_i),
    .ad_i       (cpu_ad_i),
    .per_din_i  (per_din_i),
    .ack_n_o    (cpu_ack_n_o),
    .ad_o       (cpu_ad_o),
    .ad_oe_o    (cpu_ad_oe_o),
    .per_rd_o   (per_rd_o),
    .per_wr_o   (per_wr_o),
    .per_dout_o (per_dout_o)
  );

  mbb_reset_seq #(.COLD_CYC(COLD_CYC), .WARM_CYC(WARM_CYC)) i_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .cold_n_o (cpu_cold_n_o),
    .warm_n_o (cpu_warm_n_o)
  );

  mbb_irq_map #(.INT_W(INT_W), .IR_LINE(IR_LINE), .DAC_LINE(DAC_LINE)) i_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ir_req_n_i  (ir_irq_n_i),
    .dac_req_n_i (dac_irq_n_i),
    .int_n_o     (cpu_int_n_o)
  );

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_o |-> !cpu_ad_oe_o); // R6
endmodule

// File: tb/test_mbb_bridge.sv
module test_mbb_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {wr[73], beats[72:70], first word[69:68], be_n[67:64], address[63:32], data seed[31:0]}
  localparam logic [73:0] VEC [NVEC] = '{
    {1'b0, 3'd1, 2'd1, 4'h0, 32'h1000_0A5C, 32'hA5A5_0001},
    {1'b1, 3'd1, 2'd2, 4'hC, 32'h2000_1234, 32'h1111_0000},
    {1'b0, 3'd4, 2'd0, 4'h0, 32'h0000_8F00, 32'hCAFE_0000},
    {1'b1, 3'd4, 2'd2, 4'h0, 32'hFFFF_FFF8, 32'h0BAD_0000},
    {1'b0, 3'd2, 2'd3, 4'h1, 32'h7654_3210, 32'h5555_0010},
    {1'b1, 3'd3, 2'd1, 4'hF, 32'h8000_0004, 32'hDEAD_BE00}
  };

  logic        clk, rst_n;
  logic        cpu_mclk_o;
  logic [31:0] cpu_ad_i, cpu_ad_o;
  logic        cpu_ad_oe_o;
  logic [1:0]  cpu_word_i;
  logic [3:0]  cpu_be_n_i;
  logic        cpu_ale_i, cpu_rd_n_i, cpu_wr_n_i, cpu_cip_n_i, cpu_last_n_i;
  logic        cpu_ack_n_o, cpu_cold_n_o, cpu_warm_n_o;
  logic [3:0]  cpu_int_n_o;
  logic [31:2] per_addr_o;
  logic [3:0]  per_be_o;
  logic        per_rd_o, per_wr_o;
  logic [31:0] per_dout_o, per_din_i;
  logic        ir_irq_n_i, dac_irq_n_i;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  mbb_bridge i_mbb_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_mclk_o(cpu_mclk_o),
    .cpu_ad_i(cpu_ad_i), .cpu_ad_o(cpu_ad_o), .cpu_ad_oe_o(cpu_ad_oe_o),
    .cpu_word_i(cpu_word_i), .cpu_be_n_i(cpu_be_n_i), .cpu_ale_i(cpu_ale_i),
    .cpu_rd_n_i(cpu_rd_n_i), .cpu_wr_n_i(cpu_wr_n_i), .cpu_cip_n_i(cpu_cip_n_i),
    .cpu_last_n_i(cpu_last_n_i), .cpu_ack_n_o(cpu_ack_n_o),
    .cpu_cold_n_o(cpu_cold_n_o), .cpu_warm_n_o(cpu_warm_n_o),
    .cpu_int_n_o(cpu_int_n_o), .per_addr_o(per_addr_o), .per_be_o(per_be_o),
    .per_rd_o(per_rd_o), .per_wr_o(per_wr_o), .per_dout_o(per_dout_o),
    .per_din_i(per_din_i), .ir_irq_n_i(ir_irq_n_i), .dac_irq_n_i(dac_irq_n_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_ale_i = 1'b0; cpu_rd_n_i = 1'b1; cpu_wr_n_i = 1'b1;
    cpu_cip_n_i = 1'b1; cpu_last_n_i = 1'b1;
  endtask

  // One transfer from the vector table; starts and ends at a falling edge.
  task automatic run_txn(input logic [73:0] r);
    logic        wr;
    int          nb;
    logic [1:0]  w0;
    logic [3:0]  be_n;
    logic [31:0] adr, seed;
    wr = r[73]; nb = int'(r[72:70]); w0 = r[69:68];
    be_n = r[67:64]; adr = r[63:32]; seed = r[31:0];
    cpu_ale_i = 1'b1; cpu_ad_i = adr; cpu_cip_n_i = 1'b0; cpu_be_n_i = be_n;
    @(negedge clk);
    chk("R1 upper address latched", {4'h0, per_addr_o[31:4]}, {4'h0, adr[31:4]});
    cpu_ale_i = 1'b0;
    cpu_rd_n_i = wr; cpu_wr_n_i = !wr;
    cpu_word_i = w0;
    cpu_last_n_i = (nb == 1) ? 1'b0 : 1'b1;
    cpu_ad_i = wr ? seed : 32'h0;
    per_din_i = seed;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      chk("R3 read strobe", {31'h0, per_rd_o}, {31'h0, !wr});
      chk("R4 write strobe", {31'h0, per_wr_o}, {31'h0, wr});
      chk("R6 drive during strobe", {31'h0, cpu_ad_oe_o}, {31'h0, !wr});
      chk("R5 no ack in strobe clock", {31'h0, cpu_ack_n_o}, 32'h1);
      chk("R2 word index", {30'h0, per_addr_o[3:2]}, {30'h0, 2'(w0 + 2'(b))});
      chk("R1 address held", {4'h0, per_addr_o[31:4]}, {4'h0, adr[31:4]});
      chk("R7 byte enables", {28'h0, per_be_o}, {28'h0, ~be_n});
      if (wr) chk("R4 write data", per_dout_o, seed + 32'(b));
      @(negedge clk);
      chk("R5 ack per beat", {31'h0, cpu_ack_n_o}, 32'h0);
      chk("R5 strobe gone in ack", {31'h0, per_rd_o | per_wr_o}, 32'h0);
      if (!wr) begin
        chk("R3 read data", cpu_ad_o, seed + 32'(b));
        chk("R6 drive during ack", {31'h0, cpu_ad_oe_o}, 32'h1);
      end else begin
        chk("R6 no drive on write", {31'h0, cpu_ad_oe_o}, 32'h0);
      end
      if (b < nb - 1) begin
        cpu_word_i = 2'(w0 + 2'(b + 1));
        cpu_last_n_i = (b + 1 == nb - 1) ? 1'b0 : 1'b1;
        cpu_ad_i = wr ? seed + 32'(b + 1) : 32'h0;
        per_din_i = seed + 32'(b + 1);
      end else begin
        idle_inputs();
      end
    end
    @(negedge clk);
    chk("R6 release after last", {31'h0, cpu_ad_oe_o}, 32'h0);
    chk("R5 ended after last", {31'h0, cpu_ack_n_o}, 32'h1);
    chk("R5 no further strobe", {31'h0, per_rd_o | per_wr_o}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog (R5 hang): act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    cpu_ad_i = '0; cpu_word_i = '0; cpu_be_n_i = 4'hF; per_din_i = '0;
    ir_irq_n_i = 1'b1; dac_irq_n_i = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R11 ack idle", {31'h0, cpu_ack_n_o}, 32'h1);
    chk("R11 no drive", {31'h0, cpu_ad_oe_o}, 32'h0);
    chk("R11 no strobes", {31'h0, per_rd_o | per_wr_o}, 32'h0);
    chk("R11 interrupts high", {28'h0, cpu_int_n_o}, 32'hF);
    chk("R11 cold held", {31'h0, cpu_cold_n_o}, 32'h0);
    chk("R11 warm held", {31'h0, cpu_warm_n_o}, 32'h0);
    chk("R10 master clock low", {31'h0, cpu_mclk_o}, {31'h0, clk});
    @(posedge clk); #1;
    chk("R10 master clock high", {31'h0, cpu_mclk_o}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    // Reset sequence: after k rising edges cold lifts at 64, warm at 96
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      chk("R8 cold reset phase", {31'h0, cpu_cold_n_o}, {31'h0, k >= 64});
      chk("R8 warm reset phase", {31'h0, cpu_warm_n_o}, {31'h0, k >= 96});
    end
    // Table of transfers
    for (int v = 0; v < NVEC; v++) run_txn(VEC[v]);
    // Word pins are live, byte enables combinational
    cpu_word_i = 2'd2; #1;
    chk("R2 live word pins", {30'h0, per_addr_o[3:2]}, 32'h2);
    cpu_word_i = 2'd1; #1;
    chk("R2 live word pins", {30'h0, per_addr_o[3:2]}, 32'h1);
    cpu_be_n_i = 4'b0101; #1;
    chk("R7 lane inversion", {28'h0, per_be_o}, 32'hA);
    // Address ignores the shared bus without the latch strobe
    cpu_ad_i = 32'h3333_3330;
    @(negedge clk);
    chk("R1 hold without strobe", {4'h0, per_addr_o[31:4]}, {4'h0, 28'h8000_000});
    // Write request without transfer-in-progress must not start
    cpu_wr_n_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 needs transfer in progress", {31'h0, per_wr_o | cpu_ack_n_o ^ 1'b1}, 32'h0);
    idle_inputs();
    // Interrupt routing
    ir_irq_n_i = 1'b0;
    @(negedge clk);
    chk("R9 infrared line", {28'h0, cpu_int_n_o}, 32'hE);
    dac_irq_n_i = 1'b0;
    @(negedge clk);
    chk("R9 both merged", {28'h0, cpu_int_n_o}, 32'hC);
    ir_irq_n_i = 1'b1;
    @(negedge clk);
    chk("R9 audio line only", {28'h0, cpu_int_n_o}, 32'hD);
    dac_irq_n_i = 1'b1;
    @(negedge clk);
    chk("R9 all released", {28'h0, cpu_int_n_o}, 32'hF);
    // Second reset: resets low again
    rst_n = 1'b0; #1;
    chk("R11 cold reasserted", {31'h0, cpu_cold_n_o}, 32'h0);
    chk("R11 warm reasserted", {31'h0, cpu_warm_n_o}, 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule